// File: doc/BRIEF.md
# Paged Memory Window Controller

This block sits between an 8-bit CPU with a 16-bit address bus and a 1 MB physical memory. The CPU's lower 32 kB of address space is a window. A 5-bit page register picks which 32 kB page of the physical space shows through that window. The page register supplies physical address bits 19:15. Physical pages 00h–0Fh belong to the flash device and pages 10h–1Fh belong to the expansion SRAM. The CPU's upper 32 kB always reaches a separate fixed RAM, whatever value the page register holds.

Reset clears the page register, so flash offset zero appears at CPU address 0000h and the CPU fetches its boot code from flash. Software then moves the window with an I/O write to one decoded port. Writing 10h exposes the first SRAM page. Writing 18h exposes the page that holds the low program area. Flash writes reach the device only while an in-circuit programming strap is set.

An optional low-address override forces every access below 0100h onto page 18h, so interrupt vectors and low system memory stay present while another page is mapped in. Chip selects, write enables, the physical address and the register read-back are combinational. Only the page register is clocked.

Top module: `paged_window_ctl`

## Requirements
- R1: After reset the page register holds 0, so a memory access to CPU address 0000h selects the flash with physical address 00000h.
- R2: An I/O write (`ioWr` high) to the port `PAGE_PORT` (default 40h, compared against CPU address bits 7:0) loads data bits 4:0 into the page register at the clock edge. An I/O write to any other port leaves the register unchanged.
- R3: For a memory access with CPU address bit 15 low and no override in force, the physical address is {page, CPU address bits 14:0}.
- R4: In the low window, effective page bit 4 (physical A19) equal to 0 selects the flash (`flashCs`), and equal to 1 selects the SRAM (`sramCs`).
- R5: For a memory access with CPU address bit 15 high, `upperCs` is asserted and the physical address is the CPU address zero-extended to 20 bits, whatever the page register holds.
- R6: At most one chip select is high at any time, and none is high unless `memRd` or `memWr` is high.
- R7: `flashWe` is high only for a memory write that selects the flash while `progEnable` is high. `sramWe` and `upperWe` are high for a memory write that selects their device.
- R8: With `lowOverrideEn` high, a memory access below CPU address 0100h uses page 18h in place of the page register. At address 0100h and above, or with `lowOverrideEn` low, the page register is used.
- R9: An I/O read (`ioRd` high) at `PAGE_PORT` returns {000b, page register} on `cpuDataOut`. Otherwise `cpuDataOut` is 0.
- R10: The low-address override never alters the page register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address bus (bits 7:0 double as I/O port number) |
| cpuDataIn | input | 8 | CPU write data |
| memRd | input | 1 | Memory read strobe, active high |
| memWr | input | 1 | Memory write strobe, active high |
| ioWr | input | 1 | I/O write strobe, active high |
| ioRd | input | 1 | I/O read strobe, active high |
| progEnable | input | 1 | Strap that permits flash writes |
| lowOverrideEn | input | 1 | Enables forcing of addresses below 0100h onto page 18h |
| cpuDataOut | output | 8 | Page register read-back data |
| flashCs | output | 1 | Flash chip select |
| sramCs | output | 1 | Expansion SRAM chip select |
| upperCs | output | 1 | Fixed upper RAM chip select |
| flashWe | output | 1 | Flash write enable |
| sramWe | output | 1 | Expansion SRAM write enable |
| upperWe | output | 1 | Fixed upper RAM write enable |
| physAddr | output | 20 | Physical memory address |

## Verification
The page register is the only state, and a port write takes effect at the first rising edge while `ioWr` is high. The bench therefore drives each port write for one whole clock period, starting on a falling edge, and applies the next access only after the following falling edge. Chip selects, write enables, `physAddr` and `cpuDataOut` are due in the same cycle as the address and strobes that cause them. The bench samples them 2 ns after it drives its inputs on a falling edge, well clear of the next rising edge, so no result waits on a register.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  // Strobes passed from the control decoder to the page datapath
  typedef struct packed {
    logic pageLoad;   // latch the page register this edge
    logic forceLow;   // substitute the fixed low page
    logic upperWin;   // access is to the fixed upper RAM
    logic regRead;    // drive the page register onto read data
  } winStrobe_t;
endpackage

// File: rtl/pwin_ctrl.sv
module pwin_ctrl
  import pwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PORT_W   = 8,
  parameter logic [PORT_W-1:0] PAGE_PORT = 8'h40,
  parameter logic [ADDR_W-1:0] LOW_LIMIT = 16'h0100,
  parameter bit  HAS_LOW_OVERRIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              memRd,
  input  logic              memWr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              progEnable,
  input  logic              lowOverrideEn,
  input  logic              bankSram,
  output winStrobe_t        strobes,
  output logic              flashCs,
  output logic              sramCs,
  output logic              upperCs,
  output logic              flashWe,
  output logic              sramWe,
  output logic              upperWe
);
  localparam int WIN_BIT = ADDR_W - 1;

  logic portHit;
  logic memAccess;
  logic lowWin;
  logic overrideHit;

  assign portHit   = (cpuAddr[PORT_W-1:0] == PAGE_PORT);
  assign memAccess = memRd | memWr;
  assign lowWin    = ~cpuAddr[WIN_BIT];

  generate
    if (HAS_LOW_OVERRIDE) begin : g_override
      assign overrideHit = lowOverrideEn & (cpuAddr < LOW_LIMIT);
    end else begin : g_no_override
      logic unusedOvr;
      assign unusedOvr   = lowOverrideEn;
      assign overrideHit = 1'b0;
    end
  endgenerate

  always_comb begin
    strobes.pageLoad = ioWr & portHit;
    strobes.regRead  = ioRd & portHit;
    strobes.upperWin = ~lowWin;
    strobes.forceLow = overrideHit & lowWin;
  end

  always_comb begin
    upperCs = memAccess & ~lowWin;
    flashCs = memAccess & lowWin & ~bankSram;
    sramCs  = memAccess & lowWin & bankSram;
    upperWe = memWr & upperCs;
    sramWe  = memWr & sramCs;
    flashWe = memWr & flashCs & progEnable;
  end

  // R6: chip selects mutually exclusive
  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flashCs, sramCs, upperCs}));
  // R6: no select without a memory strobe
  assert_cs_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd || memWr) |-> !(flashCs || sramCs || upperCs));
  // R7: flash writes need the programming strap
  assert_flash_we_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    flashWe |-> (progEnable && memWr));
  // R5: upper select only for the upper half
  assert_upper_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    upperCs |-> cpuAddr[WIN_BIT]);
endmodule

// File: rtl/pwin_datapath.sv
module pwin_datapath
  import pwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8,
  parameter logic [PAGE_W-1:0] LOW_PAGE = 5'h18,
  localparam int OFF_W  = ADDR_W - 1,
  localparam int PHYS_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobes,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [PAGE_W-1:0] pageData,
  output logic              bankSram,
  output logic [PHYS_W-1:0] physAddr,
  output logic [DATA_W-1:0] readData
);
  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_W-1:0] effPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageReg <= '0;
    else if (strobes.pageLoad) pageReg <= pageData;
  end

  assign effPage  = strobes.forceLow ? LOW_PAGE : pageReg;
  assign bankSram = effPage[PAGE_W-1];

  always_comb begin
    if (strobes.upperWin) physAddr = PHYS_W'(cpuAddr);
    else                  physAddr = {effPage, cpuAddr[OFF_W-1:0]};
  end

  assign readData = strobes.regRead ? DATA_W'(pageReg) : '0;

  // R2: a port write is captured on the next edge
  assert_page_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobes.pageLoad) |-> pageReg == $past(pageData));
  // R10: without a port write the register holds, override or not
  assert_page_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.pageLoad) |-> $stable(pageReg));
endmodule

// File: rtl/paged_window_ctl.sv
module paged_window_ctl
  import pwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PAGE_PORT = 8'h40,
  parameter logic [PAGE_W-1:0] LOW_PAGE  = 5'h18,
  parameter logic [ADDR_W-1:0] LOW_LIMIT = 16'h0100,
  parameter bit  HAS_LOW_OVERRIDE = 1'b1,
  localparam int PHYS_W = PAGE_W + ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuDataIn,
  input  logic              memRd,
  input  logic              memWr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              progEnable,
  input  logic              lowOverrideEn,
  output logic [DATA_W-1:0] cpuDataOut,
  output logic              flashCs,
  output logic              sramCs,
  output logic              upperCs,
  output logic              flashWe,
  output logic              sramWe,
  output logic              upperWe,
  output logic [PHYS_W-1:0] physAddr
);
  winStrobe_t strobes;
  logic bankSram;
  logic unusedDataHi;

  assign unusedDataHi = ^cpuDataIn[DATA_W-1:PAGE_W];

  pwin_ctrl #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .PAGE_PORT(PAGE_PORT),
    .LOW_LIMIT(LOW_LIMIT), .HAS_LOW_OVERRIDE(HAS_LOW_OVERRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr),
    .memRd(memRd), .memWr(memWr), .ioWr(ioWr), .ioRd(ioRd),
    .progEnable(progEnable), .lowOverrideEn(lowOverrideEn),
    .bankSram(bankSram), .strobes(strobes),
    .flashCs(flashCs), .sramCs(sramCs), .upperCs(upperCs),
    .flashWe(flashWe), .sramWe(sramWe), .upperWe(upperWe)
  );

  pwin_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .LOW_PAGE(LOW_PAGE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .pageData(cpuDataIn[PAGE_W-1:0]), .bankSram(bankSram),
    .physAddr(physAddr), .readData(cpuDataOut)
  );
endmodule

// File: tb/sim_paged_window_ctl.sv
module sim_paged_window_ctl;
  logic clk = 0;
  logic rstN = 0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuDataIn = '0;
  logic memRd = 0, memWr = 0, ioWr = 0, ioRd = 0;
  logic progEnable = 0, lowOverrideEn = 0;
  logic [7:0]  cpuDataOut;
  logic flashCs, sramCs, upperCs, flashWe, sramWe, upperWe;
  logic [19:0] physAddr;
  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  paged_window_ctl u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDataIn(cpuDataIn),
    .memRd(memRd), .memWr(memWr), .ioWr(ioWr), .ioRd(ioRd),
    .progEnable(progEnable), .lowOverrideEn(lowOverrideEn),
    .cpuDataOut(cpuDataOut), .flashCs(flashCs), .sramCs(sramCs),
    .upperCs(upperCs), .flashWe(flashWe), .sramWe(sramWe),
    .upperWe(upperWe), .physAddr(physAddr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    memRd = 0; memWr = 0; ioWr = 0; ioRd = 0;
  endtask

  task automatic writePort(logic [7:0] port, logic [7:0] val);
    @(negedge clk);
    memRd = 0; memWr = 0; ioRd = 0;
    cpuAddr = {8'h00, port}; cpuDataIn = val; ioWr = 1;
    @(negedge clk);
    ioWr = 0;
  endtask

  task automatic access(logic [15:0] a, logic rd, logic wr);
    @(negedge clk);
    ioWr = 0; ioRd = 0; cpuAddr = a; memRd = rd; memWr = wr;
    #2;
  endtask

  task automatic readPage(output logic [7:0] v);
    @(negedge clk);
    memRd = 0; memWr = 0; cpuAddr = 16'h0040; ioRd = 1;
    #2 v = cpuDataOut;
  endtask

  task automatic tReset();
    logic [7:0] v;
    access(16'h0000, 1, 0);
    chk("R1 flashCs", flashCs, 1);
    chk("R1 physAddr", physAddr, 20'h00000);
    readPage(v);
    chk("R1/R9 readback", v, 0);
  endtask

  task automatic tAllPages();
    logic [7:0] v;
    for (int p = 0; p < 32; p++) begin
      writePort(8'h40, 8'hE0 | p[7:0]);
      access(16'h1234, 1, 0);
      chk("R3 physAddr", physAddr, {12'h0, p[4:0], 15'h1234});
      chk("R4 flashCs", flashCs, !p[4]);
      chk("R4 sramCs", sramCs, p[4]);
      chk("R6 upperCs", upperCs, 0);
      readPage(v);
      chk("R9 readback", v, {3'b000, p[4:0]});
    end
  endtask

  task automatic tUpper();
    writePort(8'h40, 8'h05);
    access(16'h9ABC, 1, 0);
    chk("R5 upperCs", upperCs, 1);
    chk("R5 physAddr", physAddr, 20'h09ABC);
    chk("R6 flashCs off", flashCs, 0);
    access(16'hFFFF, 0, 1);
    chk("R7 upperWe", upperWe, 1);
    chk("R5 physAddr top", physAddr, 20'h0FFFF);
  endtask

  task automatic tFlashWrite();
    writePort(8'h40, 8'h03);
    progEnable = 0;
    access(16'h0010, 0, 1);
    chk("R7 flashCs", flashCs, 1);
    chk("R7 flashWe blocked", flashWe, 0);
    progEnable = 1;
    #1 chk("R7 flashWe allowed", flashWe, 1);
    progEnable = 0;
    writePort(8'h40, 8'h12);
    access(16'h0010, 0, 1);
    chk("R7 sramWe", sramWe, 1);
    chk("R7 flashWe sram page", flashWe, 0);
  endtask

  task automatic tIdleAndPort();
    logic [7:0] v;
    writePort(8'h40, 8'h07);
    access(16'h0200, 0, 0);
    chk("R6 idle cs", {flashCs, sramCs, upperCs}, 0);
    writePort(8'h41, 8'h1F);
    readPage(v);
    chk("R2 other port ignored", v, 8'h07);
    access(16'h0000, 0, 0);
    ioRd = 1;
    #1 chk("R9 wrong port reads 0", cpuDataOut, 0);
  endtask

  task automatic tOverride();
    logic [7:0] v;
    writePort(8'h40, 8'h03);
    lowOverrideEn = 1;
    access(16'h00FF, 1, 0);
    chk("R8 forced addr", physAddr, 20'hC00FF);
    chk("R8 forced sramCs", sramCs, 1);
    access(16'h0100, 1, 0);
    chk("R8 boundary addr", physAddr, 20'h18100);
    chk("R8 boundary flashCs", flashCs, 1);
    lowOverrideEn = 0;
    access(16'h00FF, 1, 0);
    chk("R8 disabled addr", physAddr, 20'h180FF);
    readPage(v);
    chk("R10 register kept", v, 8'h03);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tAllPages();
    tUpper();
    tFlashWrite();
    tIdleAndPort();
    tOverride();
    idle();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule